// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This block gathers seven interrupt sources of a parallel I/O peripheral into one flag register, masks them with an enable register, and drives a single interrupt request. Four external control lines, two per port, are brought into the clock domain and edge-detected. A bit in a control register picks, for each line, whether a rising or a falling edge sets its flag. A request from the shift register and two timer expiry pulses set their flags directly on every cycle they are high, with no edge filtering.

Software reaches the block through a byte-wide register interface with three fixed addresses: control, flag and enable. A flag write clears the flags written as 1. An enable write sets or clears the enable bits written as 1, with bit 7 of the data choosing between the two. The neighbouring port and shift-register logic send one-cycle strobes when they are accessed. A port access clears that port's line flags. A shift-register read clears the shift flag.

Top module: `ifu_irq_unit`

## Requirements
- R1: `irq` is high exactly when some flag bit and the same enable bit are both 1. It follows the registers with no extra cycle.
- R2: A write to address 2 with data bit 7 = 1 sets every enable bit that is 1 in data bits 6..0. With bit 7 = 0 it clears every enable bit that is 1 in data bits 6..0. The other enable bits keep their value.
- R3: Reading address 2 returns the enable bits in bits 6..0, with bit 7 always 1.
- R4: Reading address 1 returns the flags in bits 6..0. Bit 7 is 1 when at least one flag is set and enabled at the same time.
- R5: A write to address 1 clears every flag bit that is 1 in data bits 6..0 and leaves the others unchanged.
- R6: Control lines are indexed ctl_in[0]=A2, [1]=A1, [2]=B2, [3]=B1. The polarity bits are control bit 0 for A1, bit 1 for A2, bit 4 for B1 and bit 5 for B2. A value of 1 selects the rising edge and 0 selects the falling edge. A matching edge sets the line's flag 3 clock edges after the input changes. An edge of the other direction sets nothing.
- R7: The flag at bit 2 is set in every cycle that `sr_req` is high, with no edge detection. A pulse on `sr_read` clears it.
- R8: A pulse on `porta_access` clears flag bit 1 (A1). It also clears flag bit 0 (A2) unless control bit 2 (A2 independent) is 1. A pulse on `portb_access` clears flag bit 4 (B1) and flag bit 3 (B2), unless control bit 6 (B2 independent) is 1. A port strobe leaves the other port's flags alone.
- R9: Flag bit order, LSB first, is A2, A1, shift, B2, B1, timer 2, timer 1. A pulse on `t2_expire` sets bit 5 and a pulse on `t1_expire` sets bit 6.
- R10: After reset the flag, enable and control registers are zero and `irq` is low.
- R11: When a set event and a clear for the same flag occur in one cycle, the flag ends up set.
- R12: Address 0 is the control register. It reads back the last byte written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ctl_in | input | 4 | Asynchronous control lines A2, A1, B2, B1 |
| sr_req | input | 1 | Shift-register interrupt request |
| t1_expire | input | 1 | Timer 1 expiry pulse |
| t2_expire | input | 1 | Timer 2 expiry pulse |
| porta_access | input | 1 | Port A data access strobe |
| portb_access | input | 1 | Port B data access strobe |
| sr_read | input | 1 | Shift-register read strobe |
| irq | output | 1 | Interrupt request |

## Verification
The following results appear on the first clock edge after their stimulus: register writes, strobe-driven clears, the shift and timer sets, `irq` and the read data. A control-line change sets its flag only on the third edge: two synchronizer flops plus the flag register. The bench drives every input at a falling edge and samples just after a later falling edge. For each line-edge case it checks that the flag is still clear after two rising edges and set after the third. Same-cycle collisions are made by raising a set and a clear in one falling-edge slot.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
   localparam int unsigned SRC_N   = 7;
   localparam int unsigned LINES_N = 4;

   // flag bit positions (software visible)
   localparam int unsigned FL_A2 = 0;
   localparam int unsigned FL_A1 = 1;
   localparam int unsigned FL_SR = 2;
   localparam int unsigned FL_B2 = 3;
   localparam int unsigned FL_B1 = 4;
   localparam int unsigned FL_T2 = 5;
   localparam int unsigned FL_T1 = 6;

   // control register fields
   localparam int unsigned CB_A1_POL = 0;
   localparam int unsigned CB_A2_POL = 1;
   localparam int unsigned CB_A2_IND = 2;
   localparam int unsigned CB_B1_POL = 4;
   localparam int unsigned CB_B2_POL = 5;
   localparam int unsigned CB_B2_IND = 6;

   // line index on ctl_in
   localparam int unsigned LN_A2 = 0;
   localparam int unsigned LN_A1 = 1;
   localparam int unsigned LN_B2 = 2;
   localparam int unsigned LN_B1 = 3;

   function automatic int unsigned line_pol_bit(input int unsigned ln);
      case (ln)
         LN_A2:   return CB_A2_POL;
         LN_A1:   return CB_A1_POL;
         LN_B2:   return CB_B2_POL;
         default: return CB_B1_POL;
      endcase
   endfunction

   function automatic int unsigned line_flag_bit(input int unsigned ln);
      case (ln)
         LN_A2:   return FL_A2;
         LN_A1:   return FL_A1;
         LN_B2:   return FL_B2;
         default: return FL_B1;
      endcase
   endfunction
endpackage

// File: rtl/ifu_edge_det.sv
module ifu_edge_det #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   input  logic rise_sel,
   output logic hit
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ifu_edge_det: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   cur;

   assign cur = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
         prev_q <= cur;
      end
   end

   always_comb begin
      if (rise_sel) hit = cur & ~prev_q;
      else          hit = ~cur & prev_q;
   end
endmodule

// File: rtl/ifu_flag_reg.sv
module ifu_flag_reg #(
   parameter int unsigned WIDTH = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_vec,
   input  logic [WIDTH-1:0] clr_vec,
   output logic [WIDTH-1:0] flags
);
   always_ff @(posedge clk) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr_vec) | set_vec;
   end
endmodule

// File: rtl/ifu_enable_reg.sv
module ifu_enable_reg #(
   parameter int unsigned WIDTH = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [WIDTH:0]   wdata,
   output logic [WIDTH-1:0] ena
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ena <= '0;
      end else if (wr) begin
         if (wdata[WIDTH]) ena <= ena | wdata[WIDTH-1:0];
         else              ena <= ena & ~wdata[WIDTH-1:0];
      end
   end
endmodule

// File: rtl/ifu_irq_unit.sv
module ifu_irq_unit
   import ifu_pkg::*;
#(
   parameter int unsigned    ADDR_W      = 4,
   parameter int unsigned    DATA_W      = 8,
   parameter int unsigned    SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] ADDR_CTRL = 'd0,
   parameter logic [ADDR_W-1:0] ADDR_FLAG = 'd1,
   parameter logic [ADDR_W-1:0] ADDR_ENA  = 'd2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [LINES_N-1:0] ctl_in,
   input  logic               sr_req,
   input  logic               t1_expire,
   input  logic               t2_expire,
   input  logic               porta_access,
   input  logic               portb_access,
   input  logic               sr_read,
   output logic               irq
);
   localparam int unsigned NSRC = DATA_W - 1;

   generate
      if (NSRC != SRC_N) begin : g_bad_width
         $error("ifu_irq_unit: DATA_W must be SRC_N + 1");
      end
      if (ADDR_CTRL == ADDR_FLAG || ADDR_CTRL == ADDR_ENA || ADDR_FLAG == ADDR_ENA) begin : g_bad_map
         $error("ifu_irq_unit: register addresses must differ");
      end
   endgenerate

   logic [DATA_W-1:0]  ctrl_q;
   logic [NSRC-1:0]    flag_q;
   logic [NSRC-1:0]    ena_q;
   logic [NSRC-1:0]    set_vec;
   logic [NSRC-1:0]    clr_vec;
   logic [LINES_N-1:0] line_hit;
   logic [LINES_N-1:0] rise_sel;
   logic               wr_ctrl, wr_flag, wr_ena;
   logic               any_pending;

   assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
   assign wr_flag = bus_wr && (bus_addr == ADDR_FLAG);
   assign wr_ena  = bus_wr && (bus_addr == ADDR_ENA);

   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= bus_wdata;
   end

   for (genvar g = 0; g < LINES_N; g++) begin : g_line
      assign rise_sel[g] = ctrl_q[line_pol_bit(g)];
      ifu_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk      (clk),
         .rst_n    (rst_n),
         .line_in  (ctl_in[g]),
         .rise_sel (rise_sel[g]),
         .hit      (line_hit[g])
      );
   end

   always_comb begin
      set_vec = '0;
      for (int i = 0; i < LINES_N; i++) begin
         if (line_hit[i]) set_vec[line_flag_bit(i)] = 1'b1;
      end
      set_vec[FL_SR] = sr_req;
      set_vec[FL_T1] = t1_expire;
      set_vec[FL_T2] = t2_expire;
   end

   always_comb begin
      clr_vec = '0;
      if (wr_flag) clr_vec = bus_wdata[NSRC-1:0];
      if (porta_access) begin
         clr_vec[FL_A1] = 1'b1;
         if (!ctrl_q[CB_A2_IND]) clr_vec[FL_A2] = 1'b1;
      end
      if (portb_access) begin
         clr_vec[FL_B1] = 1'b1;
         if (!ctrl_q[CB_B2_IND]) clr_vec[FL_B2] = 1'b1;
      end
      if (sr_read) clr_vec[FL_SR] = 1'b1;
   end

   ifu_flag_reg #(.WIDTH(NSRC)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .flags   (flag_q)
   );

   ifu_enable_reg #(.WIDTH(NSRC)) u_ena (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_ena),
      .wdata (bus_wdata),
      .ena   (ena_q)
   );

   assign any_pending = |(flag_q & ena_q);
   assign irq         = any_pending;

   always_comb begin
      if (bus_addr == ADDR_CTRL)      bus_rdata = ctrl_q;
      else if (bus_addr == ADDR_FLAG) bus_rdata = {any_pending, flag_q};
      else if (bus_addr == ADDR_ENA)  bus_rdata = {1'b1, ena_q};
      else                            bus_rdata = '0;
   end
endmodule

// File: rtl/ifu_irq_checker.sv
module ifu_irq_checker #(
   parameter int unsigned       ADDR_W    = 4,
   parameter int unsigned       DATA_W    = 8,
   parameter logic [ADDR_W-1:0] ADDR_FLAG = 'd1,
   parameter logic [ADDR_W-1:0] ADDR_ENA  = 'd2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              sr_req,
   input logic              irq,
   input logic [DATA_W-2:0] flag_q,
   input logic [DATA_W-2:0] ena_q,
   input logic [DATA_W-2:0] set_vec
);
   localparam int unsigned N = DATA_W - 1;

   a_r4_flag_read_summary: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_FLAG) |-> (bus_rdata[N] == irq));

   a_r3_ena_read_top: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_ENA) |-> bus_rdata[N]);

   a_r2_ena_set: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_ENA && bus_wdata[N])
      |=> ((ena_q & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])));

   a_r2_ena_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_ENA && !bus_wdata[N])
      |=> ((ena_q & $past(bus_wdata[N-1:0])) == '0));

   a_r5_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_FLAG)
      |=> ((flag_q & $past(bus_wdata[N-1:0]) & ~$past(set_vec)) == '0));

   a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

   a_r7_sr_sets: assert property (@(posedge clk) disable iff (!rst_n)
      sr_req |=> flag_q[2]);
endmodule

bind ifu_irq_unit ifu_irq_checker #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .ADDR_FLAG (ADDR_FLAG),
   .ADDR_ENA  (ADDR_ENA)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .sr_req    (sr_req),
   .irq       (irq),
   .flag_q    (flag_q),
   .ena_q     (ena_q),
   .set_vec   (set_vec)
);

// File: tb/sim_ifu_irq_unit.sv
module sim_ifu_irq_unit;
   localparam logic [3:0] A_CTRL = 4'd0;
   localparam logic [3:0] A_FLAG = 4'd1;
   localparam logic [3:0] A_ENA  = 4'd2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [3:0] bus_addr = 4'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic [3:0] ctl_in = 4'd0;
   logic       sr_req = 1'b0, t1_expire = 1'b0, t2_expire = 1'b0;
   logic       porta_access = 1'b0, portb_access = 1'b0, sr_read = 1'b0;
   logic       irq;

   int n_total = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   ifu_irq_unit u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_in(ctl_in),
      .sr_req(sr_req), .t1_expire(t1_expire), .t2_expire(t2_expire),
      .porta_access(porta_access), .portb_access(portb_access),
      .sr_read(sr_read), .irq(irq)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic flags_is(input string tag, input logic [7:0] exp);
      logic [7:0] d;
      rd(A_FLAG, d);
      chk(tag, d & 8'h7f, exp);
   endtask

   task automatic line_to(input int idx, input logic v);
      @(negedge clk);
      ctl_in[idx] = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic strobe_pa(); @(negedge clk); porta_access = 1'b1; @(negedge clk); porta_access = 1'b0; endtask
   task automatic strobe_pb(); @(negedge clk); portb_access = 1'b1; @(negedge clk); portb_access = 1'b0; endtask
   task automatic strobe_t1(); @(negedge clk); t1_expire = 1'b1; @(negedge clk); t1_expire = 1'b0; endtask
   task automatic strobe_t2(); @(negedge clk); t2_expire = 1'b1; @(negedge clk); t2_expire = 1'b0; endtask
   task automatic strobe_sr(); @(negedge clk); sr_req = 1'b1; @(negedge clk); sr_req = 1'b0; endtask
   task automatic strobe_srrd(); @(negedge clk); sr_read = 1'b1; @(negedge clk); sr_read = 1'b0; endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(A_CTRL, d); chk("R10 ctrl after reset", d, 8'h00);
      rd(A_FLAG, d); chk("R10 flags after reset", d, 8'h00);
      rd(A_ENA, d);  chk("R10/R3 enable after reset", d, 8'h80);
      chk("R10 irq after reset", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_ctrl();
      logic [7:0] d;
      wr(A_CTRL, 8'h5A);
      rd(A_CTRL, d); chk("R12 ctrl readback", d, 8'h5A);
      wr(A_CTRL, 8'h00);
      rd(A_CTRL, d); chk("R12 ctrl readback zero", d, 8'h00);
   endtask

   task automatic t_edges();
      logic [7:0] d;
      wr(A_CTRL, 8'h00);
      line_to(1, 1'b1);
      flags_is("R6 A1 rising ignored in falling mode", 8'h00);
      @(negedge clk); ctl_in[1] = 1'b0;
      @(negedge clk);
      rd(A_FLAG, d); chk("R6 A1 flag not yet after 2 edges", d & 8'h7f, 8'h00);
      rd(A_FLAG, d); chk("R6 A1 falling sets bit 1 on 3rd edge", d & 8'h7f, 8'h02);
      wr(A_FLAG, 8'h7f);
      wr(A_CTRL, 8'h01);
      line_to(1, 1'b1);
      flags_is("R6 A1 rising mode sets bit 1", 8'h02);
      wr(A_FLAG, 8'h7f);
      line_to(1, 1'b0);
      flags_is("R6 A1 falling ignored in rising mode", 8'h00);
      wr(A_CTRL, 8'h20);
      line_to(2, 1'b1);
      flags_is("R6 B2 rising sets bit 3", 8'h08);
      wr(A_FLAG, 8'h7f);
      line_to(2, 1'b0);
      flags_is("R6 B2 falling ignored", 8'h00);
      line_to(3, 1'b1);
      line_to(3, 1'b0);
      flags_is("R6 B1 falling sets bit 4", 8'h10);
      wr(A_FLAG, 8'h7f);
      wr(A_CTRL, 8'h02);
      line_to(0, 1'b1);
      flags_is("R6 A2 rising sets bit 0", 8'h01);
      line_to(0, 1'b0);
      wr(A_FLAG, 8'h7f);
      flags_is("R5 all flags cleared", 8'h00);
   endtask

   task automatic t_enable();
      logic [7:0] d;
      wr(A_ENA, 8'h95);
      rd(A_ENA, d); chk("R2 enable set bits", d, 8'h95);
      wr(A_ENA, 8'h04);
      rd(A_ENA, d); chk("R2 enable clear bits", d, 8'h91);
      wr(A_ENA, 8'h7f);
      rd(A_ENA, d); chk("R2/R3 enable cleared all", d, 8'h80);
   endtask

   task automatic t_irq();
      logic [7:0] d;
      strobe_t1();
      rd(A_FLAG, d); chk("R9 timer1 sets bit 6, R4 summary low", d, 8'h40);
      chk("R1 irq low with flag disabled", {7'd0, irq}, 8'h00);
      wr(A_ENA, 8'hC0);
      rd(A_FLAG, d); chk("R4 summary bit when enabled", d, 8'hC0);
      chk("R1 irq high", {7'd0, irq}, 8'h01);
      wr(A_ENA, 8'h40);
      rd(A_FLAG, d); chk("R4 summary cleared, flag kept", d, 8'h40);
      chk("R1 irq low after disable", {7'd0, irq}, 8'h00);
      strobe_t2();
      flags_is("R9 timer2 sets bit 5", 8'h60);
      wr(A_FLAG, 8'h7f);
   endtask

   task automatic t_flag_clear();
      strobe_t1(); strobe_t2(); strobe_sr();
      flags_is("R9 bit order t1/t2/shift", 8'h64);
      wr(A_FLAG, 8'h44);
      flags_is("R5 selective clear", 8'h20);
      wr(A_FLAG, 8'h20);
      flags_is("R5 last flag cleared", 8'h00);
   endtask

   task automatic t_shift();
      @(negedge clk); sr_req = 1'b1;
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = A_FLAG; bus_wdata = 8'h04;
      @(negedge clk);
      bus_wr = 1'b0;
      flags_is("R7/R11 held request beats flag write", 8'h04);
      @(negedge clk); sr_req = 1'b0;
      strobe_srrd();
      flags_is("R7 shift read clears bit 2", 8'h00);
      strobe_sr();
      flags_is("R7 second request sets again", 8'h04);
      strobe_srrd();
   endtask

   task automatic t_ports();
      wr(A_CTRL, 8'h22);
      line_to(1, 1'b1); line_to(1, 1'b0);
      line_to(0, 1'b1);
      flags_is("R8 A1 and A2 set", 8'h03);
      strobe_pa();
      flags_is("R8 port A clears A1 and A2", 8'h00);
      wr(A_CTRL, 8'h26);
      line_to(0, 1'b0); line_to(0, 1'b1);
      line_to(1, 1'b1); line_to(1, 1'b0);
      strobe_pa();
      flags_is("R8 A2 independent survives port A", 8'h01);
      wr(A_FLAG, 8'h7f);
      wr(A_CTRL, 8'h62);
      line_to(2, 1'b1);
      line_to(3, 1'b1); line_to(3, 1'b0);
      strobe_pa();
      flags_is("R8 port A leaves B flags", 8'h18);
      strobe_pb();
      flags_is("R8 B2 independent survives port B", 8'h08);
      wr(A_CTRL, 8'h22);
      strobe_pb();
      flags_is("R8 port B clears B2 when not independent", 8'h00);
      line_to(2, 1'b0); line_to(0, 1'b0);
   endtask

   task automatic t_set_wins();
      @(negedge clk);
      t1_expire = 1'b1; bus_wr = 1'b1; bus_addr = A_FLAG; bus_wdata = 8'h40;
      @(negedge clk);
      t1_expire = 1'b0; bus_wr = 1'b0;
      flags_is("R11 timer set beats flag write", 8'h40);
      wr(A_FLAG, 8'h40);
      flags_is("R5 clear after collision", 8'h00);
   endtask

   initial begin
      repeat (1000) @(posedge clk);
      n_total++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctrl();
      t_edges();
      t_enable();
      t_irq();
      t_flag_clear();
      t_shift();
      t_ports();
      t_set_wins();
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule